// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory that holds 256 bytes. It takes SCL and SDA levels that are already synchronized to the system clock. It drives a single open-drain enable; when that enable is high, the pad pulls SDA low. The block finds start and stop conditions on the line. It checks the device address byte against a fixed code and three strap inputs, and acknowledges each byte it accepts. It loads a word address into one internal pointer and serves reads from a local byte array.

Accepted write bytes go out on a lane interface (address, data, valid strobe) to a separate page-programming block, and the local array is updated with the same bytes. A stop that follows at least one data byte sends a commit pulse to that block. While the programming block reports busy, the engine does not acknowledge its own address, so a host can poll for completion.

Reads can take three forms: from the current pointer, sequential while the host keeps acknowledging, and random. A random read is a write command carrying only a word address, followed by a repeated start and a read command.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the engine is idle, `sda_oe_o` is low, and `wr_valid_o` and `wr_commit_o` are low.
- R2: A start is a falling SDA while SCL stays high, and it restarts byte reception at the device address byte. A stop is a rising SDA while SCL stays high, and it returns the engine to idle.
- R3: The device byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `sel_i`. Bit 0 is R/W, with 1 meaning read. On a mismatch there is no acknowledge, and SDA stays released until the next start.
- R4: Every accepted address, word address or write data byte is acknowledged by holding SDA low during the 9th SCL clock.
- R5: Each accepted write data byte gives a one-cycle `wr_valid_o` pulse carrying the pointer and the byte. The pointer then steps only its low 4 bits, so a 16-byte page wraps onto itself (0x4F is followed by 0x40).
- R6: `wr_commit_o` pulses for one cycle on a stop that follows at least one accepted data byte. A stop after a word address alone, or a repeated start, gives no commit.
- R7: A read command returns the byte at the pointer, and the pointer then increments. A word-address-only write sets the pointer for the next read.
- R8: Read bytes continue while the host acknowledges. The pointer wraps from 255 to 0. On a host NACK the engine releases SDA.
- R9: A write command with only a word address, then a repeated start and a read command, returns the byte at that address.
- R10: While `busy_i` is high, the device address byte is not acknowledged.
- R11: Read data goes out MSB first. `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Synchronized serial clock level |
| sda_i | input | 1 | Synchronized serial data level |
| sel_i | input | 3 | Strap value the device byte bits 3..1 must match |
| busy_i | input | 1 | Programming block is busy |
| sda_oe_o | output | 1 | High pulls SDA low |
| wr_valid_o | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr_o | output | 8 | Address of the write byte |
| wr_data_o | output | 8 | Write byte value |
| wr_commit_o | output | 1 | Program the loaded bytes (stop after data) |

## Verification
Writes start at 0xFE, 0x00 and 0x4F, which separates the full-array wrap of reads from the in-page wrap of writes. Reads are made from the current pointer, through a word-address-only write followed by a stop, and through a repeated start. These cases tell apart the pointer-setting paths, increment-after-read and the 255-to-0 rollover. Address bytes with a wrong strap, a wrong code, and a correct address while busy each separate the acknowledge condition. A repeated start after a data byte shows that commit comes only from a stop.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_DEV,
      S_ADDR,
      S_WDAT,
      S_RDAT
   } twi_state_e;
endpackage

// File: rtl/twi_line_events.sv
module twi_line_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic ev_start,
   output logic ev_stop
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise = scl_i & ~scl_q;
   assign scl_fall = ~scl_i & scl_q;
   assign ev_start = scl_i & scl_q & sda_q & ~sda_i;
   assign ev_stop  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_ptr_step.sv
module twi_ptr_step #(
   parameter int AW         = 8,
   parameter int PAGE_BYTES = 16
) (
   input  logic [AW-1:0] ptr,
   output logic [AW-1:0] rd_next,
   output logic [AW-1:0] wr_next
);
   localparam int CW = $clog2(PAGE_BYTES);

   if (PAGE_BYTES < 2 || (1 << CW) != PAGE_BYTES || CW > AW) begin : g_bad_page
      $error("twi_ptr_step: PAGE_BYTES must be a power of two no larger than the array");
   end

   assign rd_next = ptr + 1'b1;

   if (CW == AW) begin : g_flat
      assign wr_next = rd_next;
   end else begin : g_paged
      logic [CW-1:0] col_next;
      assign col_next = ptr[CW-1:0] + 1'b1;
      assign wr_next  = {ptr[AW-1:CW], col_next};
   end
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int WORDS = 1 << AW;

   logic [DW-1:0] cells [WORDS];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
   import twi_mem_pkg::*;
#(
   parameter int         DEPTH      = 256,
   parameter int         PAGE_BYTES = 16,
   parameter int         SEL_W      = 3,
   parameter logic [3:0] DEV_CODE   = 4'b1010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             busy_i,
   output logic             sda_oe_o,
   output logic             wr_valid_o,
   output logic [7:0]       wr_addr_o,
   output logic [7:0]       wr_data_o,
   output logic             wr_commit_o
);
   localparam int AW     = $clog2(DEPTH);
   localparam int CODE_W = 7 - SEL_W;

   if (SEL_W != 3) begin : g_bad_sel
      $error("twi_mem_slave: the device byte layout needs SEL_W == 3");
   end
   if ((1 << AW) != DEPTH || AW > 8 || AW < 4) begin : g_bad_depth
      $error("twi_mem_slave: DEPTH must be a power of two from 16 to 256");
   end

   logic scl_rise, scl_fall, ev_start, ev_stop;
   twi_state_e st;
   logic [AW-1:0] ptr, rd_next, wr_next;
   logic [7:0] sh, tx, rdata;
   logic [3:0] bcnt;
   logic in_ack, rw, mack, wrote, dev_hit;

   twi_line_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .ev_start(ev_start), .ev_stop(ev_stop)
   );

   twi_ptr_step #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_step (
      .ptr(ptr), .rd_next(rd_next), .wr_next(wr_next)
   );

   twi_mem_array #(.AW(AW), .DW(8)) u_array (
      .clk(clk), .we(wr_valid_o), .waddr(wr_addr_o[AW-1:0]), .wdata(wr_data_o),
      .raddr(ptr), .rdata(rdata)
   );

   assign dev_hit = (sh[7:8-CODE_W] == DEV_CODE[CODE_W-1:0]) &&
                    (sh[SEL_W:1] == sel_i) && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         ptr         <= '0;
         sh          <= '0;
         tx          <= '0;
         bcnt        <= '0;
         in_ack      <= 1'b0;
         rw          <= 1'b0;
         mack        <= 1'b0;
         wrote       <= 1'b0;
         sda_oe_o    <= 1'b0;
         wr_valid_o  <= 1'b0;
         wr_addr_o   <= '0;
         wr_data_o   <= '0;
         wr_commit_o <= 1'b0;
      end else begin
         wr_valid_o  <= 1'b0;
         wr_commit_o <= 1'b0;
         if (ev_stop) begin
            st          <= S_IDLE;
            in_ack      <= 1'b0;
            sda_oe_o    <= 1'b0;
            wr_commit_o <= wrote;
            wrote       <= 1'b0;
         end else if (ev_start) begin
            st       <= S_DEV;
            bcnt     <= '0;
            in_ack   <= 1'b0;
            sda_oe_o <= 1'b0;
            wrote    <= 1'b0;
         end else if (st != S_IDLE) begin
            if (scl_rise) begin
               if (!in_ack) begin
                  sh   <= {sh[6:0], sda_i};
                  bcnt <= bcnt + 1'b1;
               end else begin
                  mack <= !sda_i;
               end
            end else if (scl_fall) begin
               if (in_ack) begin
                  in_ack   <= 1'b0;
                  bcnt     <= '0;
                  sda_oe_o <= 1'b0;
                  case (st)
                     S_DEV: begin
                        if (rw) begin
                           st       <= S_RDAT;
                           tx       <= rdata;
                           sda_oe_o <= !rdata[7];
                           ptr      <= rd_next;
                        end else begin
                           st <= S_ADDR;
                        end
                     end
                     S_ADDR: st <= S_WDAT;
                     S_RDAT: begin
                        if (mack) begin
                           tx       <= rdata;
                           sda_oe_o <= !rdata[7];
                           ptr      <= rd_next;
                        end else begin
                           st <= S_IDLE;
                        end
                     end
                     default: ;
                  endcase
               end else if (bcnt == 4'd8) begin
                  in_ack <= 1'b1;
                  case (st)
                     S_DEV: begin
                        if (dev_hit) begin
                           sda_oe_o <= 1'b1;
                           rw       <= sh[0];
                        end else begin
                           st <= S_IDLE;
                        end
                     end
                     S_ADDR: begin
                        sda_oe_o <= 1'b1;
                        ptr      <= sh[AW-1:0];
                     end
                     S_WDAT: begin
                        sda_oe_o   <= 1'b1;
                        wr_valid_o <= 1'b1;
                        wr_addr_o  <= 8'(ptr);
                        wr_data_o  <= sh;
                        ptr        <= wr_next;
                        wrote      <= 1'b1;
                     end
                     S_RDAT: begin
                        sda_oe_o <= 1'b0;
                        mack     <= 1'b0;
                     end
                     default: ;
                  endcase
               end else if (st == S_RDAT) begin
                  tx       <= {tx[6:0], 1'b0};
                  sda_oe_o <= !tx[6];
               end
            end
         end
      end
   end

   p_oe_low_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe_o) && !$past(ev_start) && !$past(ev_stop)) |-> !$past(scl_i));

   p_busy_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe_o) && $past(st) == S_DEV) |-> !$past(busy_i));

   p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit_o |-> $past(ev_stop));

   p_valid_in_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> $past(st) == S_WDAT);

   p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && $past(st) == S_IDLE) |-> !sda_oe_o);
endmodule

// File: tb/twi_mem_slave_bench.sv
module twi_mem_slave_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
   logic sda_oe, wr_valid, wr_commit;
   logic [7:0] wr_addr, wr_data;
   wire bus = m_sda & ~sda_oe;

   int checks = 0, errors = 0, commits = 0, oe_bad = 0;
   bit done = 0;
   logic oe_q = 1'b0, scl_q = 1'b1;
   logic [7:0] exp_rd[$];
   logic [15:0] exp_wr[$];
   logic [7:0] rx_val;
   event got;

   always #5 clk = ~clk;

   twi_mem_slave u_twi_mem_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus),
      .sel_i(3'b101), .busy_i(busy), .sda_oe_o(sda_oe),
      .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .wr_commit_o(wr_commit)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // write-lane and timing monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_valid) begin
            if (exp_wr.size() == 0) chk("R5 unexpected strobe", {wr_addr, wr_data}, 0);
            else chk("R5 write lane", {wr_addr, wr_data}, exp_wr.pop_front());
         end
         if (wr_commit) commits++;
         if (sda_oe !== oe_q && scl_q) oe_bad++;
      end
      oe_q  = sda_oe;
      scl_q = m_scl;
   end

   // read-byte monitor
   always @(got) begin
      if (exp_rd.size() == 0) chk("R7 unexpected read byte", rx_val, 0);
      else chk("R7/R8 read byte", rx_val, exp_rd.pop_front());
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic t_start();
      tick(1); m_sda = 1'b1; tick(3); m_scl = 1'b1; tick(4); m_sda = 1'b0; tick(4); m_scl = 1'b0;
   endtask

   task automatic t_stop();
      tick(1); m_sda = 1'b0; tick(3); m_scl = 1'b1; tick(4); m_sda = 1'b1; tick(4);
   endtask

   task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
      bit ak;
      for (int i = 7; i >= 0; i--) begin
         tick(1); m_sda = b[i]; tick(3); m_scl = 1'b1; tick(4); m_scl = 1'b0;
      end
      tick(1); m_sda = 1'b1; tick(3); m_scl = 1'b1; tick(2); ak = !bus; tick(2); m_scl = 1'b0;
      chk(req, ak, exp_ack);
   endtask

   task automatic recv(input bit host_ack);
      logic [7:0] d;
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(4); m_scl = 1'b1; tick(2); d[i] = bus; tick(2); m_scl = 1'b0;
      end
      tick(1); m_sda = !host_ack; tick(3); m_scl = 1'b1; tick(4); m_scl = 1'b0;
      tick(1); m_sda = 1'b1;
      rx_val = d;
      -> got;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(4);
      chk("R1 oe after reset", sda_oe, 0);
      chk("R1 valid after reset", wr_valid, 0);
      chk("R1 commit after reset", wr_commit, 0);
      rst_n = 1'b1;
      tick(4);
      chk("R1 bus idle", bus, 1);

      // busy: no address acknowledge
      busy = 1'b1;
      t_start(); send(8'hAA, 0, "R10 busy nack"); t_stop();
      busy = 1'b0;

      // strap mismatch, following byte ignored
      t_start(); send(8'hA8, 0, "R3 sel mismatch"); send(8'h00, 0, "R3 ignored byte"); t_stop();
      // wrong code
      t_start(); send(8'hBA, 0, "R3 code mismatch"); t_stop();

      // writes
      exp_wr.push_back(16'hFE11); exp_wr.push_back(16'hFF22);
      t_start(); send(8'hAA, 1, "R3 address ack"); send(8'hFE, 1, "R4 word addr ack");
      send(8'h11, 1, "R4 data ack"); send(8'h22, 1, "R4 data ack"); t_stop();
      chk("R6 commit after data", commits, 1);

      exp_wr.push_back(16'h0033);
      t_start(); send(8'hAA, 1, "R4"); send(8'h00, 1, "R4"); send(8'h33, 1, "R4"); t_stop();

      exp_wr.push_back(16'h4F55); exp_wr.push_back(16'h4066);
      t_start(); send(8'hAA, 1, "R4"); send(8'h4F, 1, "R4");
      send(8'h55, 1, "R5 page"); send(8'h66, 1, "R5 page wrap"); t_stop();
      chk("R6 commit count", commits, 3);

      // word-address-only write then current reads
      t_start(); send(8'hAA, 1, "R4"); send(8'hFF, 1, "R4"); t_stop();
      chk("R6 no commit without data", commits, 3);
      exp_rd.push_back(8'h22);
      t_start(); send(8'hAB, 1, "R3 read ack"); recv(0); t_stop();
      exp_rd.push_back(8'h33);
      t_start(); send(8'hAB, 1, "R3 read ack"); recv(0); t_stop();

      // random sequential read across 255 -> 0
      exp_rd.push_back(8'h11); exp_rd.push_back(8'h22); exp_rd.push_back(8'h33);
      t_start(); send(8'hAA, 1, "R9"); send(8'hFE, 1, "R9");
      t_start(); send(8'hAB, 1, "R9 read ack");
      recv(1); recv(1); recv(0);
      tick(2);
      chk("R8 released after nack", bus, 1);
      t_stop();

      // random read in page-wrapped location
      exp_rd.push_back(8'h66);
      t_start(); send(8'hAA, 1, "R9"); send(8'h40, 1, "R9");
      t_start(); send(8'hAB, 1, "R9"); recv(0); t_stop();

      // repeated start after data gives no commit
      exp_wr.push_back(16'h8077);
      t_start(); send(8'hAA, 1, "R4"); send(8'h80, 1, "R4"); send(8'h77, 1, "R4");
      t_start(); send(8'hA8, 0, "R2 restart then mismatch"); t_stop();
      chk("R6 no commit on restart", commits, 3);

      tick(8);
      chk("R5 write queue drained", exp_wr.size(), 0);
      chk("R7 read queue drained", exp_rd.size(), 0);
      chk("R11 oe changes only with scl low", oe_bad, 0);
      chk("R2 idle after stop", sda_oe, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule